// File: doc/BRIEF.md
# Up-Counting Compare Timer

A general-purpose timer whose counter advances by one on every prescaled tick while it is enabled. It runs in one of two modes. In free-run mode the counter wraps from full scale back to zero. In restart mode it returns to zero on the tick where it equals the first compare value. Three compare channels and the counter wrap each latch a sticky status flag. A single interrupt line is asserted while any flag is set whose enable bit is also set.

Two capture channels watch external signals. On the selected edge they copy the counter into a read-only register. Software drives the block through a simple synchronous port: writes take effect on the clock edge and reads are combinational from the address. A software reset bit clears the whole block in one write.

Top module: `ucnt_timer`

## Requirements
- R1: While control bit 0 (enable) is 1, the counter (address 9) increases by 1 on each tick. While it is 0, the counter holds its value and the prescaler is held at zero.
- R2: The prescaler register (address 1, bits 11:0, value P) produces one tick every P+1 enabled cycles. The first tick comes P+1 cycles after enable.
- R3: With control bit 9 set to 1 (free-run), a tick at full scale (all ones over the counter width) returns the counter to 0 and sets status bit 5.
- R4: With control bit 9 set to 0 (restart), a tick on which the counter equals compare 1 returns it to 0. The counting period is then compare 1 + 1 ticks.
- R5: A tick on which the counter equals compare channel N (N = 1, 2, 3 at addresses 4, 5, 6) sets status bit N-1, in either mode. Channels 2 and 3 never restart the counter.
- R6: Status (address 2) is write-1-to-clear. A set in the same cycle wins over a clear. Only bits 0, 1, 2 and 5 can ever read 1.
- R7: The interrupt-enable register (address 3) keeps bits 0, 1, 2 and 5. irq_o is 1 exactly when some status bit and the same enable bit are both 1.
- R8: Writing 1 to control bit 29, 30 or 31 sets status bit 0, 1 or 2 respectively. These force bits always read back 0.
- R9: Writing 1 to control bit 15 clears every register on the next edge, and bit 15 then reads 1 for one cycle. Writes during that cycle are ignored. On the following edge bit 15 returns to 0.
- R10: Capture channel 1 is set by control bits 17:16 and channel 2 by bits 19:18. The codes are 00 off, 01 rising, 10 falling, 11 both. On the cycle an edge is seen on cap_i[ch], the current counter value is copied to capture register ch (addresses 7, 8).
- R11: Control keeps only bits 0, 9 and 19:16, plus bit 15 as in R9. Counter and capture registers ignore writes. Unused addresses read 0, and every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| cap_i | input | 2 | Capture inputs, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
Restart mode is run with compare 1 = 5 and compare 2 = 3. The counter period then shows that only channel 1 restarts, while flag 2 still sets. A slow free-run pass with divisor 4 carries the counter through full scale. This separates the wrap and rollover flag from the restart path, and also shows each compare flag setting without a restart.

Force writes with selective interrupt enables separate the status path from the interrupt mask. The capture pins are toggled under rising-only, both-edge, falling-only and off codes. This shows that each edge code picks only its own edges. A software reset followed at once by a write checks both the one-cycle clear and the write lockout.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_CMP = 3;
  localparam int unsigned NUM_CAP = 2;

  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_PRESC  = 1;
  localparam int unsigned A_STS    = 2;
  localparam int unsigned A_IER    = 3;
  localparam int unsigned CMP_BASE = 4;
  localparam int unsigned CAP_BASE = CMP_BASE + NUM_CMP;
  localparam int unsigned A_CNT    = CAP_BASE + NUM_CAP;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_FRR   = 9;
  localparam int unsigned B_SWR   = 15;
  localparam int unsigned B_CAPM  = 16;
  localparam int unsigned B_FORCE = 29;
  localparam int unsigned B_ROV   = 5;

  localparam logic [31:0] FLAG_MASK = ((32'd1 << NUM_CMP) - 32'd1) | (32'd1 << B_ROV);
  localparam logic [31:0] CTRL_KEEP = (32'd1 << B_EN) | (32'd1 << B_FRR) |
                                      (((32'd1 << (2 * NUM_CAP)) - 32'd1) << B_CAPM);

  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_mode_e;
endpackage

// File: rtl/ucnt_prescaler.sv
module ucnt_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pc_q;

  assign tick_o = en_i && !clr_i && (pc_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pc_q <= '0;
    else if (clr_i || !en_i)      pc_q <= '0;
    else if (tick_o)              pc_q <= '0;
    else                          pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/ucnt_counter.sv
module ucnt_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NCMP  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       tick_i,
  input  logic                       frr_i,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [NCMP-1:0]            match_o,
  output logic                       wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             restart;

  for (genvar g = 0; g < NCMP; g++) begin : g_match
    assign match_o[g] = tick_i && (cnt_q == cmp_i[g]);
  end

  assign wrap_o  = tick_i && (cnt_q == {CNT_W{1'b1}});
  // only channel 0 restarts, and only outside free-run
  assign restart = !frr_i && match_o[0];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= restart ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ucnt_capture.sv
module ucnt_capture #(
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                sig_i,
  input  ucnt_pkg::cap_mode_e mode_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [CNT_W-1:0]    cap_o
);
  logic prev_q;
  logic hit;

  assign hit = (mode_i[0] && sig_i && !prev_q) || (mode_i[1] && !sig_i && prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_o <= '0;
    else if (clr_i) cap_o <= '0;
    else if (hit)   cap_o <= cnt_i;
  end
endmodule

// File: rtl/ucnt_timer.sv
module ucnt_timer
  import ucnt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CAP-1:0] cap_i,
  output logic              irq_o
);
  logic [31:0]                   ctrl_q;
  logic                          swr_q;
  logic [PRE_W-1:0]              presc_q;
  logic [31:0]                   ier_q;
  logic [NUM_CMP-1:0]            flag_q, flag_d, force_set;
  logic                          rov_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CAP-1:0][CNT_W-1:0] cap_w;
  logic [CNT_W-1:0]              cnt;
  logic [NUM_CMP-1:0]            match;
  logic                          wrap, tick;
  logic                          ctrl_wr, swr_wr, sts_wr, presc_wr, ier_wr, clr;
  logic [31:0]                   sts_vec;

  // writes are locked out while the software reset is held
  assign ctrl_wr  = we_i && !swr_q && (addr_i == ADDR_W'(A_CTRL));
  assign sts_wr   = we_i && !swr_q && (addr_i == ADDR_W'(A_STS));
  assign presc_wr = we_i && !swr_q && (addr_i == ADDR_W'(A_PRESC));
  assign ier_wr   = we_i && !swr_q && (addr_i == ADDR_W'(A_IER));
  assign swr_wr   = ctrl_wr && wdata_i[B_SWR];
  assign clr      = swr_wr || swr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      swr_q   <= 1'b0;
      presc_q <= '0;
      ier_q   <= '0;
    end else begin
      swr_q <= swr_wr;
      if (clr) begin
        ctrl_q  <= '0;
        presc_q <= '0;
        ier_q   <= '0;
      end else begin
        if (ctrl_wr)  ctrl_q  <= wdata_i & CTRL_KEEP;
        if (presc_wr) presc_q <= wdata_i[PRE_W-1:0];
        if (ier_wr)   ier_q   <= wdata_i & FLAG_MASK;
      end
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic cmp_wr;
    assign cmp_wr       = we_i && !swr_q && (addr_i == ADDR_W'(CMP_BASE + g));
    assign force_set[g] = ctrl_wr && wdata_i[B_FORCE + g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cmp_q[g] <= '0;
      else if (clr)    cmp_q[g] <= '0;
      else if (cmp_wr) cmp_q[g] <= wdata_i[CNT_W-1:0];
    end
  end

  ucnt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q[B_EN]),
    .clr_i  (clr),
    .div_i  (presc_q),
    .tick_o (tick)
  );

  ucnt_counter #(.CNT_W(CNT_W), .NCMP(NUM_CMP)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (tick),
    .frr_i   (ctrl_q[B_FRR]),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt),
    .match_o (match),
    .wrap_o  (wrap)
  );

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    ucnt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .sig_i  (cap_i[c]),
      .mode_i (cap_mode_e'(ctrl_q[B_CAPM + 2*c +: 2])),
      .cnt_i  (cnt),
      .cap_o  (cap_w[c])
    );
  end

  // sticky flags: set beats write-1-to-clear
  always_comb begin
    for (int g = 0; g < NUM_CMP; g++) begin
      flag_d[g] = (flag_q[g] && !(sts_wr && wdata_i[g])) || match[g] || force_set[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      rov_q  <= 1'b0;
    end else if (clr) begin
      flag_q <= '0;
      rov_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      rov_q  <= (rov_q && !(sts_wr && wdata_i[B_ROV])) || wrap;
    end
  end

  always_comb begin
    sts_vec = '0;
    for (int g = 0; g < NUM_CMP; g++) sts_vec[g] = flag_q[g];
    sts_vec[B_ROV] = rov_q;
  end

  assign irq_o = |(sts_vec & ier_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL))  rdata_o = ctrl_q | (32'(swr_q) << B_SWR);
    if (addr_i == ADDR_W'(A_PRESC)) rdata_o = 32'(presc_q);
    if (addr_i == ADDR_W'(A_STS))   rdata_o = sts_vec;
    if (addr_i == ADDR_W'(A_IER))   rdata_o = ier_q;
    if (addr_i == ADDR_W'(A_CNT))   rdata_o = 32'(cnt);
    for (int g = 0; g < NUM_CMP; g++)
      if (addr_i == ADDR_W'(CMP_BASE + g)) rdata_o = 32'(cmp_q[g]);
    for (int c = 0; c < NUM_CAP; c++)
      if (addr_i == ADDR_W'(CAP_BASE + c)) rdata_o = 32'(cap_w[c]);
  end
endmodule

// File: rtl/ucnt_checker.sv
module ucnt_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             tick_i,
  input logic             frr_i,
  input logic             en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp1_i,
  input logic [31:0]      sts_i,
  input logic             sts_wr_i,
  input logic [PRE_W-1:0] presc_i,
  input logic             presc_wr_i,
  input logic             swr_i
);
  a_r1_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_i));

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && presc_i != '0 && !clr_i && !presc_wr_i) |=> !tick_i);

  a_r3_full_scale_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && frr_i && cnt_i == {CNT_W{1'b1}} && !clr_i) |=> (cnt_i == '0 && sts_i[5]));

  a_r4_restart_on_cmp1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !frr_i && cnt_i == cmp1_i && !clr_i) |=> cnt_i == '0);

  a_r6_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !sts_wr_i) |=> ((sts_i & $past(sts_i)) == $past(sts_i)));

  a_r9_swr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr_i |=> !swr_i);
endmodule

bind ucnt_timer ucnt_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr),
  .tick_i     (tick),
  .frr_i      (ctrl_q[9]),
  .en_i       (ctrl_q[0]),
  .cnt_i      (cnt),
  .cmp1_i     (cmp_q[0]),
  .sts_i      (sts_vec),
  .sts_wr_i   (sts_wr),
  .presc_i    (presc_q),
  .presc_wr_i (presc_wr),
  .swr_i      (swr_q)
);

// File: tb/ucnt_timer_test.sv
module ucnt_timer_test;
  localparam int CLK_P = 10;
  localparam int CNT_W = 10;
  localparam int PRE_W = 12;
  localparam logic [31:0] MAXV = (32'd1 << CNT_W) - 1;
  localparam logic [31:0] PMSK = (32'd1 << PRE_W) - 1;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, irq;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  cap = 2'b00;
  int total = 0, fails = 0;
  bit done = 1'b0;

  ucnt_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .irq_o(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_ctrl, m_presc, m_sts, m_ier, m_cnt, m_pc;
  logic [31:0] m_cmp [3];
  logic [31:0] m_cap [2];
  logic        m_swr;
  logic [1:0]  m_prev;

  task automatic m_clear();
    m_ctrl = 0; m_presc = 0; m_sts = 0; m_ier = 0; m_cnt = 0; m_pc = 0;
    for (int i = 0; i < 3; i++) m_cmp[i] = 0;
    for (int i = 0; i < 2; i++) m_cap[i] = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear(); m_swr = 0; m_prev = 0;
    end else if (m_swr) begin
      m_clear(); m_swr = 0;
    end else if (we && addr == 0 && wdata[15]) begin
      m_clear(); m_swr = 1;
    end else begin
      logic [31:0] set, clrb;
      bit en, frr, tk;
      set = 0; clrb = 0;
      en = m_ctrl[0]; frr = m_ctrl[9];
      tk = en && (m_pc == m_presc);
      m_pc = en ? (tk ? 0 : (m_pc + 1) & PMSK) : 0;
      for (int c = 0; c < 2; c++) begin
        logic [1:0] md;
        md = m_ctrl[16 + 2*c +: 2];
        if ((md[0] && cap[c] && !m_prev[c]) || (md[1] && !cap[c] && m_prev[c]))
          m_cap[c] = m_cnt;
      end
      if (tk) begin
        for (int g = 0; g < 3; g++) if (m_cnt == m_cmp[g]) set[g] = 1;
        if (m_cnt == MAXV) set[5] = 1;
        m_cnt = (!frr && m_cnt == m_cmp[0]) ? 0 : (m_cnt + 1) & MAXV;
      end
      if (we) begin
        case (addr)
          0: begin m_ctrl = wdata & 32'h000F_0201; set = set | ((wdata >> 29) & 7); end
          1: m_presc = wdata & PMSK;
          2: clrb = wdata & 32'h27;
          3: m_ier = wdata & 32'h27;
          4, 5, 6: m_cmp[addr-4] = wdata & MAXV;
          default: ;
        endcase
      end
      m_sts = (m_sts & ~clrb) | set;
    end
    if (rst_n) m_prev = cap;
  end

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      0: return m_ctrl | (32'(m_swr) << 15);
      1: return m_presc;
      2: return m_sts;
      3: return m_ier;
      4, 5, 6: return m_cmp[a-4];
      7, 8: return m_cap[a-7];
      9: return m_cnt;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      0: return "R9 R11 ctrl";
      1: return "R2 presc";
      2: return "R5 R6 status";
      3: return "R7 ier";
      7, 8: return "R10 capture";
      9: return "R1 R4 count";
      default: return "R11 map";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(addr), rdata, m_read(addr));
      chk("R7 irq", 32'(irq), 32'(|(m_sts & m_ier)));
    end
  end

  task automatic bus(bit w, int a, logic [31:0] d);
    @(posedge clk); #1;
    we = w; addr = 4'(a); wdata = d;
  endtask
  task automatic wr(int a, logic [31:0] d); bus(1, a, d); endtask
  task automatic idle(int n, int a); repeat (n) bus(0, a, 0); endtask
  task automatic set_cap(logic [1:0] v, int a);
    @(posedge clk); #1; we = 0; addr = 4'(a); cap = v;
  endtask
  task automatic peek(int a, string tag, logic [31:0] mask, logic [31:0] exp);
    idle(1, a); @(negedge clk); chk(tag, rdata & mask, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R11 reset ctrl", rdata, 0); chk("R11 reset irq", 32'(irq), 0);
    rst_n = 1'b1;
    // restart mode, cmp1=5 cmp2=3 cmp3=100
    wr(3, 32'hFFFF_FFFF); wr(4, 5); wr(5, 3); wr(6, 100); wr(1, 0);
    wr(0, 32'h1);
    idle(25, 9);
    peek(2, "R5 ch1/ch2 flags in restart mode", 32'hFFFF_FFFF, 32'h3);
    // freeze, then clear
    wr(0, 0); wr(2, 32'hFFFF_FFFF);
    peek(2, "R6 write-1-to-clear", 32'hFFFF_FFFF, 0);
    wr(9, 32'h3FF); idle(2, 9);
    // free-run through full scale, divisor 4
    wr(1, 3); wr(0, 32'h201);
    idle(4300, 9);
    peek(2, "R3 rollover and free-run flags", 32'hFFFF_FFFF, 32'h27);
    // force events
    wr(0, 0); wr(2, 32'hFF); wr(3, 32'h20); wr(0, 32'hE000_0000);
    peek(2, "R8 force sets flags", 32'hFFFF_FFFF, 32'h7);
    peek(0, "R8 force bits read 0", 32'hFFFF_FFFF, 0);
    @(negedge clk); chk("R7 masked irq", 32'(irq), 0);
    wr(3, 32'h1);
    idle(1, 2); @(negedge clk); chk("R7 enabled irq", 32'(irq), 1);
    // capture: ch1 rising, ch2 both edges
    wr(1, 0); wr(0, 32'h000D_0201);
    idle(10, 7);
    set_cap(2'b11, 7); idle(7, 8);
    set_cap(2'b00, 8); idle(5, 7); idle(2, 8);
    // ch1 falling, ch2 off
    wr(0, 32'h0002_0201); idle(3, 7);
    set_cap(2'b11, 7); idle(4, 7);
    set_cap(2'b00, 7); idle(4, 8); idle(2, 7);
    set_cap(2'b10, 8); idle(3, 8);
    // software reset with a locked-out write
    wr(0, 32'h8000); wr(0, 32'h1);
    peek(0, "R9 swr self-clears, write ignored", 32'hFFFF_FFFF, 0);
    idle(5, 9);
    peek(9, "R9 counter stays cleared", 32'hFFFF_FFFF, 0);
    idle(1, 12);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule